// File: doc/BRIEF.md
# SPI Serial Clock Prescaler with Two Divisor Encodings

This block turns the core clock into the serial clock timing for an SPI shifter. An 8-bit prescale field sets the divisor, and a mode input picks how that field is read. In the compact encoding the divisor is even and lies between 4 and 30. In the wide encoding a 4-bit multiplier is shifted left by a 3-bit exponent, which gives divisors up to 1920. The three exponent bits are not adjacent in the field.

While `run` is high the block counts core cycles and toggles a serial clock level. A low phase comes first, then a high phase. A one-cycle strobe marks the first cycle of each high phase and the first cycle of each low phase, so the shift logic can launch and capture data on those strobes. Dropping `run` returns the clock to idle at once, and the count restarts from zero on the next start. A field that describes no usable divisor raises `bad_setting` and keeps the clock idle.

Top module: `spi_sck_prescaler`

## Requirements
- R1: With `ext_mode`=0 and `presc_field[4]`=1, the divisor is 2 × `presc_field[3:0]`. Bits [7:5] have no effect.
- R2: With `ext_mode`=0, `bad_setting` is 1 when `presc_field[4]`=0 or when `presc_field[3:0]` is below 2 (a divisor under 4). Otherwise it is 0.
- R3: With `ext_mode`=1, the divisor is `presc_field[3:0]` shifted left by {`presc_field[7:6]`,`presc_field[4]`}, so the largest divisor is 1920. Bit 5 has no effect.
- R4: With `ext_mode`=1, `bad_setting` is 1 when the divisor is 0 or 1. Otherwise it is 0.
- R5: The high phase lasts floor(D/2) core cycles and the low phase lasts D − floor(D/2) core cycles.
- R6: After `run` is first sampled high, `sck_level` stays low for one full low phase and then rises. A `run` low for even one cycle restarts this count from zero.
- R7: `lead_pulse` is high for exactly the first cycle of each high phase. `trail_pulse` is high for exactly the first cycle of each low phase that follows a high phase. The two are never high together.
- R8: In the cycle after `run` is sampled low, or after a setting is sampled invalid, `sck_level`, `lead_pulse` and `trail_pulse` are all 0, and they stay 0 while that lasts.
- R9: While `rst_n` is low, `sck_level`, `lead_pulse` and `trail_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode | input | 1 | 0 selects the compact even-divisor encoding, 1 selects the multiplier-and-exponent encoding |
| presc_field | input | 8 | Prescale field |
| run | input | 1 | High while an exchange is in progress |
| sck_level | output | 1 | Divided serial clock level, idle low |
| lead_pulse | output | 1 | Strobe in the first cycle of each high phase |
| trail_pulse | output | 1 | Strobe in the first cycle of each low phase after a high phase |
| bad_setting | output | 1 | The current field gives no usable divisor |

## Verification
The bench builds the block with its default parameters. The counter is therefore 11 bits wide, and the 1920 divisor at the top of the wide encoding can be exercised. The bench measures the length of each phase in cycles, for odd divisors (3 and 5) as well as even ones. It also tests field values with the ignored bits set, and settings just below the valid range in both encodings. Directed runs drop `run` in the middle of a low phase and in the middle of a high phase, then check that the next start waits a full low phase again.

// File: rtl/sckp_pkg.sv
package sckp_pkg;
  localparam int FIELD_W     = 8;
  localparam int MULT_W      = 4;
  localparam int EXP_W       = 3;
  localparam int DIV_W       = MULT_W + (1 << EXP_W) - 1;
  localparam int LEG_MIN_DIV = 4;
  localparam int EXT_MIN_DIV = 2;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             bad;
  } div_cfg_t;

  // Compact encoding: field[4] flags a valid value, field[3:0] is half the divisor
  function automatic div_cfg_t compact_div(input logic [FIELD_W-1:0] f);
    div_cfg_t r;
    r.div = DIV_W'({f[MULT_W-1:0], 1'b0});
    r.bad = !f[4] || (r.div < DIV_W'(LEG_MIN_DIV));
    return r;
  endfunction

  // Wide encoding: multiplier in field[3:0], exponent gathered from bits 7,6,4
  function automatic div_cfg_t wide_div(input logic [FIELD_W-1:0] f);
    div_cfg_t r;
    logic [EXP_W-1:0] e;
    e     = {f[7:6], f[4]};
    r.div = DIV_W'(f[MULT_W-1:0]) << e;
    r.bad = r.div < DIV_W'(EXT_MIN_DIV);
    return r;
  endfunction
endpackage

// File: rtl/sckp_decode.sv
module sckp_decode
  import sckp_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int DW = DIV_W
) (
  input  logic          ext_mode,
  input  logic [FW-1:0] field,
  output logic [DW-1:0] div,
  output logic [DW-1:0] hi_len,
  output logic [DW-1:0] lo_len,
  output logic          bad
);
  div_cfg_t cfg;

  always_comb begin
    cfg    = ext_mode ? wide_div(FIELD_W'(field)) : compact_div(FIELD_W'(field));
    div    = DW'(cfg.div);
    bad    = cfg.bad;
    hi_len = div >> 1;
    lo_len = div - hi_len;
  end
endmodule

// File: rtl/sckp_phase_ctr.sv
module sckp_phase_ctr #(
  parameter int DW = sckp_pkg::DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  logic [DW-1:0] hi_len,
  input  logic [DW-1:0] lo_len,
  output logic          level,
  output logic          lead,
  output logic          trail
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] limit;
  logic          half_done;
  logic          active;

  assign active    = run && !hold;
  assign limit     = level ? hi_len : lo_len;
  assign half_done = (cnt + DW'(1)) >= limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (!active) begin
      cnt   <= '0;
      level <= 1'b0;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (half_done) begin
      cnt   <= '0;
      level <= !level;
      lead  <= !level;
      trail <= level;
    end else begin
      cnt   <= cnt + DW'(1);
      lead  <= 1'b0;
      trail <= 1'b0;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && trail)); // R7
  AST_LEAD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    lead |-> (level && !$past(level))); // R7
  AST_TRAIL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    trail |-> (!level && $past(level))); // R7
  AST_RISE_HAS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (level && !$past(level)) |-> lead); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!level && !lead && !trail)); // R8
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import sckp_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic [FW-1:0] presc_field,
  input  logic          run,
  output logic          sck_level,
  output logic          lead_pulse,
  output logic          trail_pulse,
  output logic          bad_setting
);
  logic [DW-1:0] dec_div;
  logic [DW-1:0] dec_hi;
  logic [DW-1:0] dec_lo;
  logic          dec_bad;

  sckp_decode #(.FW(FW), .DW(DW)) u_decode (
    .ext_mode (ext_mode),
    .field    (presc_field),
    .div      (dec_div),
    .hi_len   (dec_hi),
    .lo_len   (dec_lo),
    .bad      (dec_bad)
  );

  sckp_phase_ctr #(.DW(DW)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .hold   (dec_bad),
    .hi_len (dec_hi),
    .lo_len (dec_lo),
    .level  (sck_level),
    .lead   (lead_pulse),
    .trail  (trail_pulse)
  );

  assign bad_setting = dec_bad;

  AST_VALID_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_bad |-> (dec_div >= DW'(EXT_MIN_DIV))); // R4
  AST_DIV_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    dec_div <= DW'(1920)); // R3
  AST_COMPACT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !dec_bad) |-> (!dec_div[0] && dec_div >= DW'(LEG_MIN_DIV))); // R1
  AST_PHASES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hi + dec_lo == dec_div) && (dec_lo >= dec_hi)); // R5
endmodule

// File: tb/test_spi_sck_prescaler.sv
module test_spi_sck_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_mode = 1'b0;
  logic [7:0] presc_field = 8'h00;
  logic       run = 1'b0;
  logic       sck_level, lead_pulse, trail_pulse, bad_setting;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_sck_prescaler i_spi_sck_prescaler (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .presc_field(presc_field),
    .run(run), .sck_level(sck_level), .lead_pulse(lead_pulse),
    .trail_pulse(trail_pulse), .bad_setting(bad_setting)
  );

  typedef struct packed {
    logic        mode;
    logic [7:0]  field;
    logic        bad;
    logic [10:0] hi;
    logic [10:0] lo;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h12, 1'b0, 11'd2,   11'd2},   // div 4
    '{1'b0, 8'h1F, 1'b0, 11'd15,  11'd15},  // div 30
    '{1'b0, 8'hF3, 1'b0, 11'd3,   11'd3},   // upper bits ignored, div 6
    '{1'b0, 8'h11, 1'b1, 11'd0,   11'd0},   // div 2 too small
    '{1'b0, 8'h0A, 1'b1, 11'd0,   11'd0},   // bit 4 clear
    '{1'b1, 8'h03, 1'b0, 11'd1,   11'd2},   // div 3
    '{1'b1, 8'h25, 1'b0, 11'd2,   11'd3},   // bit 5 ignored, div 5
    '{1'b1, 8'h15, 1'b0, 11'd5,   11'd5},   // 5<<1
    '{1'b1, 8'h47, 1'b0, 11'd14,  11'd14},  // 7<<2
    '{1'b1, 8'hDF, 1'b0, 11'd960, 11'd960}, // 15<<7 = 1920
    '{1'b1, 8'h50, 1'b1, 11'd0,   11'd0},   // multiplier 0
    '{1'b1, 8'h01, 1'b1, 11'd0,   11'd0},   // div 1
    '{1'b1, 8'h91, 1'b0, 11'd16,  11'd16}   // 1<<5
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic want, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sck_level != want && n < 5000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    string rq;
    // R9: outputs quiet in reset even with run high
    run = 1'b1;
    ext_mode = 1'b0;
    presc_field = 8'h12;
    repeat (4) @(negedge clk);
    chk(!sck_level && !lead_pulse && !trail_pulse, "R9", int'(sck_level), 0);
    run = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sck_level && !lead_pulse && !trail_pulse, "R9", int'(sck_level), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      run = 1'b0;
      ext_mode = VEC[i].mode;
      presc_field = VEC[i].field;
      @(negedge clk);
      rq = VEC[i].mode ? (VEC[i].bad ? "R4" : "R3") : (VEC[i].bad ? "R2" : "R1");
      chk(bad_setting == VEC[i].bad, rq, int'(bad_setting), int'(VEC[i].bad));
      run = 1'b1;
      if (VEC[i].bad) begin
        n = 0;
        repeat (40) begin
          @(negedge clk);
          if (sck_level || lead_pulse || trail_pulse) n++;
        end
        chk(n == 0, "R8", n, 0);
      end else begin
        wait_level(1'b1, n);
        chk(n == int'(VEC[i].lo), "R6", n, int'(VEC[i].lo));
        chk(lead_pulse && !trail_pulse, "R7", int'(lead_pulse), 1);
        wait_level(1'b0, n);
        chk(n == int'(VEC[i].hi), rq == "R1" ? "R5 R1" : "R5 R3", n, int'(VEC[i].hi));
        chk(trail_pulse && !lead_pulse, "R7", int'(trail_pulse), 1);
        wait_level(1'b1, n);
        chk(n == int'(VEC[i].lo), "R5", n, int'(VEC[i].lo));
        run = 1'b0;
        @(negedge clk);
        chk(!sck_level && !lead_pulse && !trail_pulse, "R8", int'(sck_level), 0);
      end
      run = 1'b0;
    end

    // R6: drop run during the low phase, the next start waits a full low phase
    ext_mode = 1'b0;
    presc_field = 8'h1F;
    @(negedge clk);
    run = 1'b1;
    repeat (5) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    run = 1'b1;
    wait_level(1'b1, n);
    chk(n == 15, "R6", n, 15);
    // R8: drop run during the high phase, no trailing strobe, level idle
    repeat (4) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk(!sck_level && !trail_pulse, "R8", int'(sck_level) + int'(trail_pulse), 0);
    run = 1'b1;
    wait_level(1'b1, n);
    chk(n == 15, "R6", n, 15);
    run = 1'b0;

    // R8: setting turns invalid while running
    @(negedge clk);
    run = 1'b1;
    repeat (3) @(negedge clk);
    presc_field = 8'h0F;
    @(negedge clk);
    chk(bad_setting && !sck_level, "R8", int'(sck_level), 0);

    finish_run();
  end
endmodule